// File: doc/BRIEF.md
# Packed-Lane Shift-and-Insert Unit

This unit executes the lane-wise left-shift-with-insert operation for a vector register pair. The caller presents a 32-bit instruction word, the source vector and the present contents of the destination vector, all with a single-cycle strobe. The unit decodes the operation form, the lane width, the total vector width and the shift distance from the instruction word. One cycle later it returns the merged destination value. Within each lane, the shifted source supplies every bit at or above the shift point, and the old destination keeps every bit below it.

Register reads and writes, privilege checks and any other opcodes belong to the surrounding pipeline. An encoding that this unit does not accept is reported on an error output. For such an encoding the write enable stays low and the result is driven to zero. The operation has no condition flags, and the unit has no flag output.

Top module: `sli_insert_unit`

## Requirements
- R1: In every active lane of width E and shift s, result bits [s-1:0] equal the destination lane and bits [E-1:s] equal source lane bits [E-1-s:0]. Source bits pushed past the top of a lane never reach the next lane.
- R2: The lane width comes from the highest set bit of the 4-bit field instr[22:19]: bit 0 gives 8, bit 1 gives 16, bit 2 gives 32 and bit 3 gives 64. The shift equals the 7-bit value instr[22:16] minus the lane width.
- R3: The vector form is recognised when (instr & 0xBF80FC00) == 0x2F005400. In that form, instr[30] = 1 processes all 128 bits and instr[30] = 0 processes the low 64 bits.
- R4: For a vector form with instr[30] = 0, result bits 127:64 are zero.
- R5: The scalar form is recognised when (instr & 0xFF80FC00) == 0x7F005400. It handles one 64-bit lane, and bits 127:64 of the result are zero. It is legal only when instr[22] = 1.
- R6: An illegal encoding gives out_error = 1, out_wr_en = 0 and out_result = 0 in the done cycle. Illegal encodings are: a word that matches neither form, instr[22:19] = 0, a vector form with 64-bit lanes and instr[30] = 0, and a scalar form with instr[22] = 0.
- R7: A strobe sampled at a rising edge gives out_done = 1 for exactly the following cycle. In that cycle exactly one of out_wr_en and out_error is 1. With no strobe, all three are 0. After reset, all three are 0.
- R8: A shift of zero returns the source lane unchanged, and no destination bit survives.
- R9: The register index fields instr[9:0] have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue strobe; captures the other inputs |
| in_instr | input | 32 | Instruction word |
| in_src | input | 128 | Source vector |
| in_dst | input | 128 | Current destination vector |
| out_done | output | 1 | One-cycle completion pulse |
| out_wr_en | output | 1 | Result is valid and may be written |
| out_error | output | 1 | Encoding was rejected |
| out_result | output | 128 | Merged destination value |

## Verification
The bench builds the unit with its default parameters: a 128-bit vector, an 8-bit minimum lane and four lane sizes. These settings make every lane width from 8 to 64 bits reachable, along with both vector widths and the scalar form. Random instruction words cover every shift distance at every lane width. Directed cases cover zero and maximum shifts, each illegal-encoding class, and index-field variation, so that both the lane boundaries and the width-selection paths are exercised.

// File: rtl/sli_pkg.sv
package sli_pkg;

    localparam int VEC_W      = 128;
    localparam int HALF_W     = VEC_W / 2;
    localparam int INSTR_W    = 32;
    localparam int NUM_SIZES  = 4;
    localparam int MIN_ELEM_W = 8;
    localparam int MAX_ELEM_W = MIN_ELEM_W << (NUM_SIZES - 1);
    localparam int SHAMT_W    = $clog2(MAX_ELEM_W);
    localparam int IMM_W      = 7;

    localparam logic [INSTR_W-1:0] VEC_FIX_MASK = 32'hBF80_FC00;
    localparam logic [INSTR_W-1:0] VEC_FIX_VAL  = 32'h2F00_5400;
    localparam logic [INSTR_W-1:0] SCA_FIX_MASK = 32'hFF80_FC00;
    localparam logic [INSTR_W-1:0] SCA_FIX_VAL  = 32'h7F00_5400;

    localparam int WIDE_BIT = 30;
    localparam int SZ_HI    = 22;
    localparam int SZ_LO    = 19;
    localparam int IMM_LO   = 16;

    typedef enum logic [1:0] {
        LANE_8  = 2'd0,
        LANE_16 = 2'd1,
        LANE_32 = 2'd2,
        LANE_64 = 2'd3
    } lane_sz_e;

    typedef enum logic [1:0] {
        FORM_NONE   = 2'd0,
        FORM_VECTOR = 2'd1,
        FORM_SCALAR = 2'd2
    } form_e;

    typedef struct packed {
        logic                legal;
        form_e               form;
        logic                full_width;
        lane_sz_e            lane_sz;
        logic [SHAMT_W-1:0]  shamt;
    } decode_t;

    typedef struct packed {
        logic                valid;
        logic [INSTR_W-1:0]  instr;
        logic [VEC_W-1:0]    src;
        logic [VEC_W-1:0]    dst;
    } issue_t;

    function automatic logic [IMM_W-1:0] lane_bits(input lane_sz_e sz);
        return IMM_W'(MIN_ELEM_W) << sz;
    endfunction

    function automatic form_e match_form(input logic [INSTR_W-1:0] w);
        if ((w & VEC_FIX_MASK) == VEC_FIX_VAL)
            return FORM_VECTOR;
        else if ((w & SCA_FIX_MASK) == SCA_FIX_VAL)
            return FORM_SCALAR;
        else
            return FORM_NONE;
    endfunction

endpackage

// File: rtl/sli_decode.sv
module sli_decode
    import sli_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output decode_t            dec
);
    logic [SZ_HI-SZ_LO:0] size_field;
    logic [IMM_W-1:0]     imm7;
    logic                 size_zero;
    lane_sz_e             sz;
    form_e                form;
    logic                 unused_fields;

    assign size_field    = instr[SZ_HI:SZ_LO];
    assign imm7          = instr[SZ_HI:IMM_LO];
    assign form          = match_form(instr);
    assign size_zero     = (size_field == '0);
    assign unused_fields = ^instr[IMM_LO-1:0];

    always_comb begin
        casez (size_field)
            4'b1???: sz = LANE_64;
            4'b01??: sz = LANE_32;
            4'b001?: sz = LANE_16;
            default: sz = LANE_8;
        endcase
    end

    always_comb begin
        dec.form       = form;
        dec.lane_sz    = sz;
        dec.shamt      = SHAMT_W'(imm7 - lane_bits(sz));
        dec.full_width = (form == FORM_VECTOR) && instr[WIDE_BIT];
        unique case (form)
            FORM_VECTOR: dec.legal = !size_zero && !((sz == LANE_64) && !instr[WIDE_BIT]);
            FORM_SCALAR: dec.legal = (sz == LANE_64);
            default:     dec.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/sli_lane_merge.sv
module sli_lane_merge
    import sli_pkg::*;
#(
    parameter int ELEM_W = 8
) (
    input  logic [ELEM_W-1:0]  src,
    input  logic [ELEM_W-1:0]  dst,
    input  logic [SHAMT_W-1:0] shamt,
    output logic [ELEM_W-1:0]  merged
);
    logic [ELEM_W-1:0] keep_hi;
    logic [ELEM_W-1:0] moved;

    assign keep_hi = {ELEM_W{1'b1}} << shamt;
    assign moved   = src << shamt;
    assign merged  = (dst & ~keep_hi) | (moved & keep_hi);
endmodule

// File: rtl/sli_lane_array.sv
module sli_lane_array
    import sli_pkg::*;
#(
    parameter int TOTAL_W = 128,
    parameter int ELEM_W  = 8
) (
    input  logic [TOTAL_W-1:0] src,
    input  logic [TOTAL_W-1:0] dst,
    input  logic [SHAMT_W-1:0] shamt,
    output logic [TOTAL_W-1:0] merged
);
    localparam int LANES = TOTAL_W / ELEM_W;

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        sli_lane_merge #(.ELEM_W(ELEM_W)) u_merge (
            .src    (src[ln*ELEM_W +: ELEM_W]),
            .dst    (dst[ln*ELEM_W +: ELEM_W]),
            .shamt  (shamt),
            .merged (merged[ln*ELEM_W +: ELEM_W])
        );
    end
endmodule

// File: rtl/sli_insert_unit.sv
module sli_insert_unit
    import sli_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [31:0]        in_instr,
    input  logic [127:0]       in_src,
    input  logic [127:0]       in_dst,
    output logic               out_done,
    output logic               out_wr_en,
    output logic               out_error,
    output logic [127:0]       out_result
);
    issue_t              issue_q;
    decode_t             dec;
    logic [VEC_W-1:0]    by_size [NUM_SIZES];
    logic [VEC_W-1:0]    picked;
    logic [VEC_W-1:0]    shaped;

    always_ff @(posedge clk) begin
        if (rst) begin
            issue_q <= '0;
        end else begin
            issue_q.valid <= in_valid;
            if (in_valid) begin
                issue_q.instr <= in_instr;
                issue_q.src   <= in_src;
                issue_q.dst   <= in_dst;
            end
        end
    end

    sli_decode u_decode (
        .instr (issue_q.instr),
        .dec   (dec)
    );

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
        localparam int EW = MIN_ELEM_W << k;
        sli_lane_array #(.TOTAL_W(VEC_W), .ELEM_W(EW)) u_lanes (
            .src    (issue_q.src),
            .dst    (issue_q.dst),
            .shamt  (dec.shamt),
            .merged (by_size[k])
        );
    end

    assign picked = by_size[dec.lane_sz];

    always_comb begin
        shaped = picked;
        if (!dec.full_width)
            shaped[VEC_W-1:HALF_W] = '0;
    end

    assign out_done   = issue_q.valid;
    assign out_wr_en  = issue_q.valid && dec.legal;
    assign out_error  = issue_q.valid && !dec.legal;
    assign out_result = (issue_q.valid && dec.legal) ? shaped : '0;
endmodule

// File: rtl/sli_insert_chk.sv
module sli_insert_chk
    import sli_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [31:0]  in_instr,
    input logic         out_done,
    input logic         out_wr_en,
    input logic         out_error,
    input logic [127:0] out_result
);
    logic is_vec;
    logic is_sca;
    logic unused_low;

    assign is_vec     = (in_instr & VEC_FIX_MASK) == VEC_FIX_VAL;
    assign is_sca     = (in_instr & SCA_FIX_MASK) == SCA_FIX_VAL;
    assign unused_low = ^in_instr[15:0];

    a_r7_done_after_strobe: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_done);

    a_r7_quiet_without_strobe: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_done && !out_wr_en && !out_error));

    a_r7_one_outcome: assert property (@(posedge clk) disable iff (rst)
        out_done |-> (out_wr_en ^ out_error));

    a_r6_error_zero_result: assert property (@(posedge clk) disable iff (rst)
        out_error |-> (out_result == '0));

    a_r6_size_zero_rejected: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_instr[22:19] == 4'b0000) |=> out_error);

    a_r6_no_match_rejected: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !is_vec && !is_sca) |=> out_error);

    a_r4_upper_half_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_vec && !in_instr[30]) |=> (out_result[127:64] == '0));

    a_r5_scalar_size_check: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_sca) |=> (out_error == !$past(in_instr[22])));

    a_r5_scalar_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_sca) |=> (out_result[127:64] == '0));
endmodule

bind sli_insert_unit sli_insert_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_instr   (in_instr),
    .out_done   (out_done),
    .out_wr_en  (out_wr_en),
    .out_error  (out_error),
    .out_result (out_result)
);

// File: tb/sli_insert_unit_tb_top.sv
`timescale 1ns/1ps
module sli_insert_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [31:0]  in_instr = '0;
    logic [127:0] in_src = '0;
    logic [127:0] in_dst = '0;
    logic         out_done, out_wr_en, out_error;
    logic [127:0] out_result;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sli_insert_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
        .in_src(in_src), .in_dst(in_dst), .out_done(out_done),
        .out_wr_en(out_wr_en), .out_error(out_error), .out_result(out_result)
    );

    function automatic void ref_model(input logic [31:0] w, input logic [127:0] s,
                                      input logic [127:0] d, output logic [127:0] r,
                                      output bit err);
        bit vec, sca;
        int es, sh, width;
        logic [63:0] lm, ls, ld, m, rl;
        vec = (w & 32'hBF80FC00) == 32'h2F005400;
        sca = (w & 32'hFF80FC00) == 32'h7F005400;
        if (w[22]) es = 64; else if (w[21]) es = 32;
        else if (w[20]) es = 16; else if (w[19]) es = 8; else es = 0;
        err = !(vec || sca) || es == 0 || (vec && es == 64 && !w[30]) || (sca && es != 64);
        r = '0;
        if (err) return;
        width = (vec && w[30]) ? 128 : 64;
        sh = int'(w[22:16]) - es;
        lm = (es == 64) ? '1 : ((64'd1 << es) - 64'd1);
        for (int e = 0; e < width / es; e++) begin
            ls = 64'(s >> (e * es)) & lm;
            ld = 64'(d >> (e * es)) & lm;
            m  = (lm << sh) & lm;
            rl = ((ld & ~m) | ((ls << sh) & m)) & lm;
            r  = r | (128'(rl) << (e * es));
        end
    endfunction

    function automatic logic [31:0] mk_vec(input bit q, input logic [6:0] imm, input logic [9:0] regs);
        return 32'h2F005400 | (32'(q) << 30) | (32'(imm) << 16) | 32'(regs);
    endfunction

    function automatic logic [31:0] mk_sca(input logic [6:0] imm, input logic [9:0] regs);
        return 32'h7F005400 | (32'(imm[5:0]) << 16) | (32'(imm[6]) << 22) | 32'(regs);
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] w, input logic [127:0] s, input logic [127:0] d,
                         input string req, output logic [127:0] got);
        logic [127:0] exp;
        bit err;
        ref_model(w, s, d, exp, err);
        @(negedge clk);
        in_valid = 1'b1; in_instr = w; in_src = s; in_dst = d;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_done && out_wr_en == !err && out_error == err, {req, " R7 flags"},
              128'({out_done, out_wr_en, out_error}), 128'({1'b1, !err, err}));
        check(out_result == exp, req, out_result, exp);
        got = out_result;
    endtask

    initial begin
        logic [127:0] g1, g2, s, d;
        logic [31:0] w;
        logic [3:0] hsel;
        int es;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(!out_done && !out_wr_en && !out_error, "R7 reset", 128'({out_done, out_wr_en, out_error}), '0);
        rst = 1'b0;

        s = {4{32'hA5C3_1E7F}}; d = {4{32'h0F0F_F0F0}};
        // R8: zero shift at each lane size
        for (int k = 0; k < 4; k++) begin
            es = 8 << k;
            issue(mk_vec(1'b1, 7'(es), 10'h0), s, d, "R8 zero shift", g1);
            check(g1 == s, "R8 copy", g1, s);
        end
        // R1/R2: maximum shift at each lane size
        for (int k = 0; k < 4; k++) begin
            es = 8 << k;
            issue(mk_vec(1'b1, 7'(2 * es - 1), 10'h3FF), s, d, "R1 max shift", g1);
        end
        issue(mk_vec(1'b1, 7'd16 + 7'd5, 10'h21), s, d, "R2 lane16 shift5", g1);
        // R3/R4: half width
        issue(mk_vec(1'b0, 7'd35, 10'h12), s, d, "R4 half width", g1);
        check(g1[127:64] == '0, "R4 upper zero", g1, '0);
        issue(mk_vec(1'b1, 7'd35, 10'h12), s, d, "R3 full width", g1);
        // R6: illegal cases
        issue(mk_vec(1'b1, 7'd3, 10'h0), s, d, "R6 size zero", g1);
        issue(mk_vec(1'b0, 7'd70, 10'h0), s, d, "R6 lane64 half", g1);
        issue(32'h0E20_1C00, s, d, "R6 no match", g1);
        // R5: scalar forms
        issue(mk_sca(7'd64 + 7'd13, 10'h55), s, d, "R5 scalar legal", g1);
        issue(mk_sca(7'd64, 10'h55), s, d, "R5 scalar shift0", g1);
        check(g1 == {64'h0, s[63:0]}, "R5 scalar copy", g1, {64'h0, s[63:0]});
        w = 32'h7F005400 | (32'h5 << 19);
        issue(w, s, d, "R5 scalar bad size", g1);
        // R9: index fields ignored
        issue(mk_vec(1'b1, 7'd41, 10'h000), s, d, "R9 regs a", g1);
        issue(mk_vec(1'b1, 7'd41, 10'h3A7), s, d, "R9 regs b", g2);
        check(g1 == g2, "R9 regs no effect", g2, g1);
        // R7: idle cycle
        @(negedge clk);
        check(!out_done && !out_wr_en && !out_error, "R7 idle", 128'({out_done, out_wr_en, out_error}), '0);

        // random R1/R2/R3
        for (int i = 0; i < 400; i++) begin
            s = {$urandom(), $urandom(), $urandom(), $urandom()};
            d = {$urandom(), $urandom(), $urandom(), $urandom()};
            hsel = 4'($urandom_range(1, 15));
            case ($urandom_range(0, 9))
                0: w = mk_sca({hsel, 3'($urandom())}, 10'($urandom()));
                1: w = $urandom();
                default: w = mk_vec(1'($urandom()), {hsel, 3'($urandom())}, 10'($urandom()));
            endcase
            issue(w, s, d, "R1 random", g1);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #4_000_000;
        if (!finished) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog R7 actual=hang expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule